// File: doc/BRIEF.md
# Interrupt event and mask unit

This block collects interrupt events for a network media access controller and presents a single interrupt request line to the host processor. There are three banks, A, B and C. Each bank has a 16-bit event register and a 16-bit enable (mask) register. Hardware sources raise event bits with one-cycle pulses. Each event bit is sticky: it stays set until the host clears it by writing a 1 to that bit position. The request line goes high when at least one event bit is set while its enable bit in the same bank is also set.

The host reaches the block through a simple synchronous register port. On a read, the data comes back combinationally in the same cycle. Address bit 2 chooses between the event view (0) and the enable view (1). Address bits 1:0 choose the bank: 0 is A, 1 is B and 2 is C. Bank index 3 is unmapped.

Only bits 2:0 of bank C are implemented:
- Bit 2 means a fresh ring latency figure has been captured.
- Bit 1 means the latency timer wrapped.
- Bit 0 means the token counter wrapped.

There are two resets. The power-up reset clears everything. The controller soft reset clears the events and the request line but leaves the enables as they were.

The request line comes from a two-state machine. The states are IRQ_IDLE and IRQ_ACTIVE, and there are two transitions:
- RAISE: IRQ_IDLE to IRQ_ACTIVE, taken when the enabled-event OR is 1.
- DROP: IRQ_ACTIVE to IRQ_IDLE, taken when the enabled-event OR is 0 or a soft reset occurs.

Top module: `intr_evt_unit`

## Requirements
- R1: While por_n is low, and after it is released, every event and enable register reads 0 and irq is 0.
- R2: A write with reg_addr[2]=1 and reg_addr[1:0]=k (k in 0..2) stores reg_wdata into enable register k, limited to that bank's implemented bits. A later read of the same address returns the stored value.
- R3: A 1 on bit i of a source pulse vector sets event bit i of that bank at the next clock edge. The bit then stays set through any number of idle cycles.
- R4: A write with reg_addr[2]=0 and reg_addr[1:0]=k clears every event bit of bank k where reg_wdata has a 1. Bits where reg_wdata has a 0 keep their value.
- R5: When a source pulse and a host clear hit the same event bit in the same cycle, the bit ends up set.
- R6: irq equals, one cycle late, the OR over all banks of (event AND enable). A change to an event or enable bit therefore shows on irq at the following clock edge.
- R7: In bank C, bits 15:3 of both the event and the enable register always read 0. Source pulses and writes to those bits have no effect.
- R8: A soft_rst cycle clears all event bits and drives irq to 0 at that edge. Enable registers keep their contents.
- R9: With reg_en high and reg_addr[1:0]=3, reg_rdata reads 0 and writes change no register. With reg_en low, reg_rdata is 0.
- R10: The request state machine takes RAISE from IRQ_IDLE to IRQ_ACTIVE when enabled events exist. It takes DROP back to IRQ_IDLE when none remain or on soft reset. irq is high exactly in IRQ_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| soft_rst | input | 1 | Controller soft reset, synchronous, active high |
| src_a | input | 16 | Event pulses for bank A |
| src_b | input | 16 | Event pulses for bank B |
| src_c | input | 16 | Event pulses for bank C (bits 2:0 used) |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Bit 2: enable view; bits 1:0: bank index |
| reg_wdata | input | 16 | Write data (enable value or clear pattern) |
| reg_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that source vectors are held for exactly one clock and that soft_rst is sampled only while por_n is high. The stickiness check also assumes that, in any cycle without a soft reset or an event-view write, no agent other than the sources touches the event registers. The stimulus drives every input only on the falling clock edge, so each input stays stable across a full rising edge. Every power-up reset pulse is applied through a task that releases por_n on a falling edge. Collision cycles, reserved-bit pokes and unmapped addresses are deliberately mixed into otherwise random traffic, so that the one-cycle irq lag can be checked against simultaneous set, clear and enable changes.

// File: rtl/intr_evt_pkg.sv
package intr_evt_pkg;

    localparam int NUM_BANKS = 3;
    localparam int SEL_W     = 2;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;

    typedef enum logic [0:0] {
        VIEW_EVENT  = 1'b0,
        VIEW_ENABLE = 1'b1
    } reg_view_t;

    function automatic logic bank_valid(input logic [SEL_W-1:0] sel);
        return int'(sel) < NUM_BANKS;
    endfunction

endpackage

// File: rtl/intr_evt_bank.sv
module intr_evt_bank #(
    parameter int                REG_W = 16,
    parameter logic [REG_W-1:0]  IMPL  = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst,
    input  logic [REG_W-1:0] src,
    input  logic             ev_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ev_q,
    output logic [REG_W-1:0] en_q
);

    logic [REG_W-1:0] clr_pat;
    logic [REG_W-1:0] ev_d;

    always_comb begin
        clr_pat = ev_wr ? wdata : '0;
        // set has priority over clear in the same cycle
        ev_d    = ((ev_q & ~clr_pat) | src) & IMPL;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ev_q <= '0;
        end else if (soft_rst) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    // enables only see the power-up reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wdata & IMPL;
        end
    end

endmodule

// File: rtl/intr_irq_fsm.sv
module intr_irq_fsm
    import intr_evt_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic soft_rst,
    input  logic pending,
    output logic irq
);

    irq_state_t state_q;
    irq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending && !soft_rst) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending || soft_rst) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/intr_evt_unit.sv
module intr_evt_unit
    import intr_evt_pkg::*;
#(
    parameter int               REG_W  = 16,
    parameter int               ADDR_W = 3,
    parameter logic [REG_W-1:0] IMPL_A = '1,
    parameter logic [REG_W-1:0] IMPL_B = '1,
    parameter logic [REG_W-1:0] IMPL_C = 16'h0007
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [REG_W-1:0]  src_c,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    localparam int ALL_W = NUM_BANKS * REG_W;
    localparam logic [ALL_W-1:0] IMPL_ALL = {IMPL_C, IMPL_B, IMPL_A};

    logic [ALL_W-1:0] src_all;
    logic [ALL_W-1:0] ev_all;
    logic [ALL_W-1:0] en_all;
    logic [SEL_W-1:0] bank_sel;
    reg_view_t        view;
    logic             wr_hit;
    logic             pending;

    assign src_all  = {src_c, src_b, src_a};
    assign bank_sel = reg_addr[SEL_W-1:0];
    assign view     = reg_view_t'(reg_addr[ADDR_W-1]);
    assign wr_hit   = reg_en && reg_wr && bank_valid(bank_sel);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic ev_wr;
        logic en_wr;
        assign ev_wr = wr_hit && (view == VIEW_EVENT)  && (int'(bank_sel) == b);
        assign en_wr = wr_hit && (view == VIEW_ENABLE) && (int'(bank_sel) == b);

        intr_evt_bank #(
            .REG_W (REG_W),
            .IMPL  (IMPL_ALL[b*REG_W +: REG_W])
        ) bank_i (
            .clk      (clk),
            .por_n    (por_n),
            .soft_rst (soft_rst),
            .src      (src_all[b*REG_W +: REG_W]),
            .ev_wr    (ev_wr),
            .en_wr    (en_wr),
            .wdata    (reg_wdata),
            .ev_q     (ev_all[b*REG_W +: REG_W]),
            .en_q     (en_all[b*REG_W +: REG_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_en && int'(bank_sel) == b) begin
                reg_rdata = (view == VIEW_ENABLE) ? en_all[b*REG_W +: REG_W]
                                                  : ev_all[b*REG_W +: REG_W];
            end
        end
    end

    assign pending = |(ev_all & en_all);

    intr_irq_fsm irq_fsm_i (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .pending  (pending),
        .irq      (irq)
    );

endmodule

// File: rtl/intr_evt_chk.sv
module intr_evt_chk #(
    parameter int                      REG_W    = 16,
    parameter int                      ADDR_W   = 3,
    parameter int                      ALL_W    = 48,
    parameter logic [ALL_W-1:0]        IMPL_ALL = '1
) (
    input logic              clk,
    input logic              por_n,
    input logic              soft_rst,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [ALL_W-1:0]  src_all,
    input logic [ALL_W-1:0]  ev_all,
    input logic [ALL_W-1:0]  en_all,
    input logic              irq
);

    logic ev_write;
    logic en_write;
    assign ev_write = reg_en && reg_wr && !reg_addr[ADDR_W-1];
    assign en_write = reg_en && reg_wr &&  reg_addr[ADDR_W-1];

    // R7: unimplemented bits never hold a one
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        ((ev_all | en_all) & ~IMPL_ALL) == '0);

    // R3: without a clear or soft reset, no event bit falls
    a_r3_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && !ev_write) |=> ((ev_all & $past(ev_all)) == $past(ev_all)));

    // R5: a pulse always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst |=> ((ev_all & $past(src_all & IMPL_ALL)) == $past(src_all & IMPL_ALL)));

    // R6: request follows enabled events one cycle late
    a_r6_irq_lag: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst |=> (irq == $past(|(ev_all & en_all))));

    // R8: soft reset wipes events and request
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (ev_all == '0 && !irq));

    // R8: soft reset leaves enables alone
    a_r8_enable_keep: assert property (@(posedge clk) disable iff (!por_n)
        (soft_rst && !en_write) |=> $stable(en_all));

endmodule

bind intr_evt_unit intr_evt_chk #(
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .ALL_W    (ALL_W),
    .IMPL_ALL (IMPL_ALL)
) chk_i (
    .clk      (clk),
    .por_n    (por_n),
    .soft_rst (soft_rst),
    .reg_en   (reg_en),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .src_all  (src_all),
    .ev_all   (ev_all),
    .en_all   (en_all),
    .irq      (irq)
);

// File: tb/intr_evt_unit_tb_top.sv
module intr_evt_unit_tb_top;

    localparam int W = 16;
    localparam logic [W-1:0] IMPL [3] = '{16'hFFFF, 16'hFFFF, 16'h0007};

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0, src_c = '0;
    logic         reg_en = 1'b0, reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq;

    always #10 clk = ~clk;

    intr_evt_unit dut_i (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference state
    logic [W-1:0] ev_m [3];
    logic [W-1:0] en_m [3];
    logic         irq_m;
    int           nvec = 0;
    int           nfail = 0;
    string        cur_tag = "R1";
    bit           finished = 0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int b = 0; b < 3; b++) begin ev_m[b] = '0; en_m[b] = '0; end
            irq_m = 1'b0;
        end else begin
            logic pend;
            logic [W-1:0] srcs [3];
            pend = 1'b0;
            for (int b = 0; b < 3; b++) pend = pend | (|(ev_m[b] & en_m[b]));
            srcs[0] = src_a; srcs[1] = src_b; srcs[2] = src_c;
            for (int b = 0; b < 3; b++) begin
                if (soft_rst) ev_m[b] = '0;
                else begin
                    logic [W-1:0] clr;
                    clr = (reg_en && reg_wr && !reg_addr[2] && reg_addr[1:0] == b) ? reg_wdata : '0;
                    ev_m[b] = ((ev_m[b] & ~clr) | srcs[b]) & IMPL[b];
                end
                if (reg_en && reg_wr && reg_addr[2] && reg_addr[1:0] == b)
                    en_m[b] = reg_wdata & IMPL[b];
            end
            irq_m = soft_rst ? 1'b0 : pend;
        end
    end

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        if (a[1:0] == 2'd3) return '0;
        return a[2] ? en_m[a[1:0]] : ev_m[a[1:0]];
    endfunction

    task automatic compare_outputs();
        logic [W-1:0] exp;
        nvec++;
        if (irq !== irq_m) begin
            nfail++;
            $display("FAIL %s irq actual=%0b expected=%0b", cur_tag, irq, irq_m);
        end
        if (reg_en) begin
            exp = model_read(reg_addr);
            nvec++;
            if (reg_rdata !== exp) begin
                nfail++;
                $display("FAIL %s rdata@%0d actual=%h expected=%h", cur_tag, reg_addr, reg_rdata, exp);
            end
        end
    endtask

    task automatic step(input logic en, input logic wr, input logic [2:0] a,
                        input logic [W-1:0] wd, input logic [W-1:0] sa,
                        input logic [W-1:0] sb, input logic [W-1:0] sc, input logic sr);
        @(negedge clk);
        compare_outputs();
        reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        src_a = sa; src_b = sb; src_c = sc; soft_rst = sr;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd(input logic [2:0] a); step(1, 0, a, 0, 0, 0, 0, 0); endtask
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d); step(1, 1, a, d, 0, 0, 0, 0); endtask

    task automatic power_up();
        @(negedge clk);
        compare_outputs();
        por_n = 1'b0;
        reg_en = 0; reg_wr = 0; src_a = 0; src_b = 0; src_c = 0; soft_rst = 0;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1: everything reads zero after power-up
        cur_tag = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a));
        idle();

        // R2: enable write/read-back
        cur_tag = "R2";
        wr(3'd4, 16'hA5A5); wr(3'd5, 16'h0F0F); wr(3'd6, 16'h0003);
        rd(3'd4); rd(3'd5); rd(3'd6);

        // R3: pulses set sticky bits
        cur_tag = "R3";
        step(0, 0, 0, 0, 16'h0100, 16'h0000, 16'h0004, 0);
        repeat (5) idle();
        rd(3'd0); rd(3'd2);

        // R6 / R10: bank C bit 2 is not enabled (mask 3) -> only bank A drives irq
        cur_tag = "R10";
        wr(3'd4, 16'h0000); idle(); idle();
        wr(3'd6, 16'h0004); idle(); idle();
        cur_tag = "R6";
        wr(3'd6, 16'h0000); idle(); idle();

        // R4: write-one-to-clear, zeros leave bits alone
        cur_tag = "R4";
        step(0, 0, 0, 0, 16'h00FF, 0, 0, 0);
        wr(3'd0, 16'h000F); rd(3'd0);
        wr(3'd0, 16'h0000); rd(3'd0);

        // R5: set beats clear on the same bit
        cur_tag = "R5";
        step(1, 1, 3'd1, 16'h0001, 0, 16'h0001, 0, 0);
        rd(3'd1);

        // R7: reserved bits in bank C
        cur_tag = "R7";
        step(0, 0, 0, 0, 0, 0, 16'hFFF8, 0);
        wr(3'd6, 16'hFFFF); rd(3'd6); rd(3'd2);
        step(0, 0, 0, 0, 0, 0, 16'h0003, 0); rd(3'd2); idle(); idle();

        // R9: unmapped bank index
        cur_tag = "R9";
        wr(3'd3, 16'hFFFF); wr(3'd7, 16'hFFFF);
        rd(3'd3); rd(3'd7); rd(3'd6); rd(3'd2);

        // R8: soft reset clears events and irq, keeps enables
        cur_tag = "R8";
        step(0, 0, 0, 0, 0, 0, 0, 1);
        rd(3'd2); rd(3'd6); rd(3'd4); rd(3'd5); idle();

        // R1: power-up reset mid-run wipes enables too
        cur_tag = "R1";
        power_up();
        rd(3'd6); rd(3'd5); rd(3'd2);

        // R6: random traffic against the reference
        cur_tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] sa, sb, sc;
            logic en, w, sr;
            sa = $urandom & $urandom & $urandom;
            sb = $urandom & $urandom & $urandom;
            sc = $urandom & $urandom;
            en = ($urandom % 3) != 0;
            w  = $urandom % 2;
            sr = ($urandom % 60) == 0;
            step(en, w, 3'($urandom), 16'($urandom & $urandom), sa, sb, sc, sr);
            if (($urandom % 700) == 0) power_up();
        end
        idle(); idle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule